// File: doc/BRIEF.md
# Character-Cell Video Generator with Shared Glyph and Screen Memory

This block turns a small on-chip memory into a monochrome text display. It runs a horizontal and a vertical position counter from a pixel clock and produces active-low horizontal and vertical sync, a blank flag and a colour value. The visible area is a grid of 8x8-pixel cells. For each cell the block reads a character code from the screen region of the memory. It then reads one row of that character's bitmap from the glyph region of the same memory and sends the eight bits out as pixels, leftmost pixel first. With the default parameters the visible area is 64 columns by 48 rows (512x384 pixels). A line is 640 pixel clocks and a frame is 566 lines, which gives about 60 Hz from a 21.75 MHz pixel clock.

A host reaches the same memory through a second port on its own clock. That port has a write enable, an address, write data and registered read data. The host can change the characters on the screen. Because the glyph bitmaps sit in the same array, the host can also redraw the font or paint small bitmap graphics. The array comes up holding a computed test pattern, so a picture appears before any host access. The sync, blank and colour outputs leave the block together, four pixel clocks after the counter position they describe.

Top module: `txtvid_top`

## Requirements
- R1: While `prst_n` is low, and during the first four pixel clocks after it rises, `hsync_n`=1, `vsync_n`=1, `blank`=1 and `rgb`=0.
- R2: A line lasts H_TOTAL pixel clocks and a frame lasts V_TOTAL lines, both counted from position (0,0) after reset. A position (h,v) is visible when h < COLS*8 and v < ROWS*8. `blank` is 0 exactly for visible positions.
- R3: `hsync_n` is 0 for H_SYNC pixel clocks, at positions h from COLS*8+H_FP up to but not including COLS*8+H_FP+H_SYNC, and 1 otherwise.
- R4: `vsync_n` is 0 for all lines v from ROWS*8+V_FP up to but not including ROWS*8+V_FP+V_SYNC, and 1 otherwise. This always falls inside blanking.
- R5: All four video outputs show position (h,v) exactly four pixel clocks after the counters stand at (h,v), so sync, blank and colour stay aligned.
- R6: The pixel at visible (h,v) is bit (7 - h mod 8) of the memory byte at GLYPH_BASE + code*8 + (v mod 8). Here GLYPH_BASE = COLS*ROWS and code is the byte at address (v/8)*COLS + h/8. The most significant bit is the leftmost pixel.
- R7: `rgb` equals FG_COLOR when the pixel bit is 1 at a visible position. Otherwise `rgb` is 0, and it is always 0 while `blank` is 1.
- R8: After configuration, a screen address a (a < GLYPH_BASE) holds a mod NGLYPH. A glyph address a holds ((a - GLYPH_BASE) mod 256) XOR 8'hA5.
- R9: A host write (`h_we`=1 at a rising `hclk` edge) stores `h_wdata` at `h_addr`. It changes the picture from the next time that cell or glyph row is fetched.
- R10: `h_rdata` takes the byte at `h_addr` on each rising `hclk` edge. When a write hits the same address at that edge, it returns the old byte. Addresses at or above COLS*ROWS + NGLYPH*8 read as 0, and writes to them leave the memory unchanged.
- R11: Only the low log2(NGLYPH) bits of a character code select a glyph. The upper bits of the code are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock |
| prst_n | input | 1 | Active-low reset of the video side |
| hclk | input | 1 | Host port clock, independent of pclk |
| h_we | input | 1 | Host write enable |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered on hclk |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible area |
| rgb | output | RGB_W | Pixel colour, FG_COLOR or 0 |

## Verification
A wrong counter or sync decode shows up on `hsync_n` or `blank` within one line. A vertical error shows up on `vsync_n` within one frame. A slip in the fetch phase or the shift register moves every pixel in a cell, so the first visible cell of the first line already disagrees with a reference that scans the memory contents. Damaged memory contents or host-port write or read paths appear on `h_rdata` one host clock after the access, and on `rgb` in the next frame that shows the affected cell. The bench keeps its own copy of the memory, updated on every host write, and predicts all four video outputs on every pixel clock.

// File: rtl/txtvid_pkg.sv
package txtvid_pkg;

   localparam int CELL   = 8;
   localparam int CELL_W = $clog2(CELL);

   // power-up content of the shared array
   function automatic logic [7:0] init_byte(input int addr, input int glyph_base, input int nglyph);
      if (addr < glyph_base)
         return 8'(addr % nglyph);
      else
         return 8'((addr - glyph_base) % 256) ^ 8'hA5;
   endfunction

endpackage

// File: rtl/txtvid_ram.sv
module txtvid_ram
   import txtvid_pkg::*;
#(
   parameter int DEPTH      = 4096,
   parameter int AW         = 12,
   parameter int GLYPH_BASE = 3072,
   parameter int NGLYPH     = 128
) (
   input  logic          hclk,
   input  logic          h_we,
   input  logic [AW-1:0] h_addr,
   input  logic [7:0]    h_wdata,
   output logic [7:0]    h_rdata,
   input  logic          pclk,
   input  logic [AW-1:0] v_addr,
   output logic [7:0]    v_rdata
);

   logic [7:0] mem [DEPTH];
   logic       h_hit;

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = init_byte(i, GLYPH_BASE, NGLYPH);
   end

   assign h_hit = int'(h_addr) < DEPTH;

   always_ff @(posedge hclk) begin
      if (h_we && h_hit) mem[h_addr] <= h_wdata;
      h_rdata <= h_hit ? mem[h_addr] : 8'h00;
   end

   always_ff @(posedge pclk) begin
      v_rdata <= mem[v_addr];
   end

endmodule

// File: rtl/txtvid_timing.sv
module txtvid_timing #(
   parameter int H_TOTAL = 640,
   parameter int V_TOTAL = 566,
   parameter int ACT_W   = 512,
   parameter int ACT_H   = 384,
   parameter int H_FP    = 16,
   parameter int H_SYNC  = 64,
   parameter int V_FP    = 3,
   parameter int V_SYNC  = 4,
   parameter int HW      = 10,
   parameter int VW      = 10
) (
   input  logic          pclk,
   input  logic          prst_n,
   output logic [HW-1:0] hcnt,
   output logic [VW-1:0] vcnt,
   output logic          vis,
   output logic          hs_n,
   output logic          vs_n
);

   localparam int HS_LO = ACT_W + H_FP;
   localparam int HS_HI = HS_LO + H_SYNC;
   localparam int VS_LO = ACT_H + V_FP;
   localparam int VS_HI = VS_LO + V_SYNC;

   logic h_last, v_last;

   assign h_last = int'(hcnt) == H_TOTAL - 1;
   assign v_last = int'(vcnt) == V_TOTAL - 1;

   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (h_last) begin
         hcnt <= '0;
         vcnt <= v_last ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   always_comb begin
      vis  = (int'(hcnt) < ACT_W) && (int'(vcnt) < ACT_H);
      hs_n = !((int'(hcnt) >= HS_LO) && (int'(hcnt) < HS_HI));
      vs_n = !((int'(vcnt) >= VS_LO) && (int'(vcnt) < VS_HI));
   end

endmodule

// File: rtl/txtvid_fetch.sv
module txtvid_fetch
   import txtvid_pkg::*;
#(
   parameter int COLS       = 64,
   parameter int GLYPH_BASE = 3072,
   parameter int NGLYPH     = 128,
   parameter int AW         = 12,
   parameter int HW         = 10,
   parameter int VW         = 10
) (
   input  logic          pclk,
   input  logic          prst_n,
   input  logic [HW-1:0] hcnt,
   input  logic [VW-1:0] vcnt,
   input  logic          vis,
   input  logic [7:0]    rd,
   output logic [AW-1:0] addr,
   output logic          pix
);

   localparam int GB = $clog2(NGLYPH);
   localparam logic [CELL_W-1:0] PH_CODE = CELL_W'(0);
   localparam logic [CELL_W-1:0] PH_LOAD = CELL_W'(2);

   logic [CELL_W-1:0] phase;
   logic [CELL-1:0]   shreg;
   int                cell_col, cell_row, glyph_idx, glyph_row;

   assign phase = hcnt[CELL_W-1:0];

   always_comb begin
      cell_col  = int'(hcnt[HW-1:CELL_W]);
      cell_row  = int'(vcnt[VW-1:CELL_W]);
      glyph_idx = int'(rd[GB-1:0]);
      glyph_row = int'(vcnt[CELL_W-1:0]);
      if (phase == PH_CODE)
         addr = vis ? AW'(cell_row * COLS + cell_col) : '0;
      else
         addr = AW'(GLYPH_BASE + glyph_idx * CELL + glyph_row);
   end

   // phase 0 reads the code, phase 1 the glyph row, phase 2 loads the shifter
   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n)
         shreg <= '0;
      else if (phase == PH_LOAD)
         shreg <= rd;
      else
         shreg <= {shreg[CELL-2:0], 1'b0};
   end

   assign pix = shreg[CELL-1];

endmodule

// File: rtl/txtvid_dly.sv
module txtvid_dly #(
   parameter int             W      = 1,
   parameter int             STAGES = 1,
   parameter logic [W-1:0]   RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_wire
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic [W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= {STAGES{RST}};
            else        pipe <= {pipe[STAGES-2:0], d};
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/txtvid_top.sv
module txtvid_top
   import txtvid_pkg::*;
#(
   parameter int                COLS     = 64,
   parameter int                ROWS     = 48,
   parameter int                NGLYPH   = 128,
   parameter int                H_TOTAL  = 640,
   parameter int                H_FP     = 16,
   parameter int                H_SYNC   = 64,
   parameter int                V_TOTAL  = 566,
   parameter int                V_FP     = 3,
   parameter int                V_SYNC   = 4,
   parameter int                RGB_W    = 3,
   parameter logic [RGB_W-1:0]  FG_COLOR = 3'b010,
   parameter int                ADDR_W   = $clog2(COLS * ROWS + NGLYPH * 8)
) (
   input  logic              pclk,
   input  logic              prst_n,
   input  logic              hclk,
   input  logic              h_we,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [7:0]        h_wdata,
   output logic [7:0]        h_rdata,
   output logic              hsync_n,
   output logic              vsync_n,
   output logic              blank,
   output logic [RGB_W-1:0]  rgb
);

   localparam int ACT_W      = COLS * CELL;
   localparam int ACT_H      = ROWS * CELL;
   localparam int GLYPH_BASE = COLS * ROWS;
   localparam int DEPTH      = GLYPH_BASE + NGLYPH * CELL;
   localparam int HW         = $clog2(H_TOTAL);
   localparam int VW         = $clog2(V_TOTAL);
   localparam int FETCH_LAT  = 3;

   // elaboration-time parameter checks
   if (H_TOTAL % CELL != 0 || ACT_W + H_FP + H_SYNC > H_TOTAL || H_SYNC < 1) begin : g_bad_h
      $error("txtvid_top: horizontal timing parameters inconsistent");
   end
   if (ACT_H + V_FP + V_SYNC > V_TOTAL || V_SYNC < 1) begin : g_bad_v
      $error("txtvid_top: vertical timing parameters inconsistent");
   end
   if ((NGLYPH & (NGLYPH - 1)) != 0 || NGLYPH < 2 || NGLYPH > 256) begin : g_bad_glyph
      $error("txtvid_top: NGLYPH must be a power of two from 2 to 256");
   end
   if (ADDR_W < $clog2(DEPTH)) begin : g_bad_aw
      $error("txtvid_top: ADDR_W too small for the shared array");
   end

   logic [HW-1:0]     hcnt;
   logic [VW-1:0]     vcnt;
   logic              vis, hs_n, vs_n, pix;
   logic [ADDR_W-1:0] v_addr;
   logic [7:0]        v_rdata;
   logic [2:0]        ctl_d;

   txtvid_timing #(
      .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .ACT_W(ACT_W), .ACT_H(ACT_H),
      .H_FP(H_FP), .H_SYNC(H_SYNC), .V_FP(V_FP), .V_SYNC(V_SYNC),
      .HW(HW), .VW(VW)
   ) u_timing (
      .pclk(pclk), .prst_n(prst_n), .hcnt(hcnt), .vcnt(vcnt),
      .vis(vis), .hs_n(hs_n), .vs_n(vs_n)
   );

   txtvid_ram #(
      .DEPTH(DEPTH), .AW(ADDR_W), .GLYPH_BASE(GLYPH_BASE), .NGLYPH(NGLYPH)
   ) u_ram (
      .hclk(hclk), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
      .pclk(pclk), .v_addr(v_addr), .v_rdata(v_rdata)
   );

   txtvid_fetch #(
      .COLS(COLS), .GLYPH_BASE(GLYPH_BASE), .NGLYPH(NGLYPH),
      .AW(ADDR_W), .HW(HW), .VW(VW)
   ) u_fetch (
      .pclk(pclk), .prst_n(prst_n), .hcnt(hcnt), .vcnt(vcnt), .vis(vis),
      .rd(v_rdata), .addr(v_addr), .pix(pix)
   );

   // align control with the pixel that leaves the shifter
   txtvid_dly #(.W(3), .STAGES(FETCH_LAT), .RST(3'b110)) u_dly (
      .clk(pclk), .rst_n(prst_n), .d({hs_n, vs_n, vis}), .q(ctl_d)
   );

   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         hsync_n <= 1'b1;
         vsync_n <= 1'b1;
         blank   <= 1'b1;
         rgb     <= '0;
      end else begin
         hsync_n <= ctl_d[2];
         vsync_n <= ctl_d[1];
         blank   <= !ctl_d[0];
         rgb     <= (ctl_d[0] && pix) ? FG_COLOR : '0;
      end
   end

endmodule

// File: rtl/txtvid_chk.sv
module txtvid_chk #(
   parameter int H_TOTAL = 640,
   parameter int H_SYNC  = 64,
   parameter int COLS    = 64,
   parameter int RGB_W   = 3
) (
   input logic             pclk,
   input logic             prst_n,
   input logic             hsync_n,
   input logic             vsync_n,
   input logic             blank,
   input logic [RGB_W-1:0] rgb
);

   int   hs_low, since_fall, vis_run;
   logic hs_prev, seen_fall, hs_fall;

   assign hs_fall = hs_prev && !hsync_n;

   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         hs_low     <= 0;
         since_fall <= 0;
         vis_run    <= 0;
         hs_prev    <= 1'b1;
         seen_fall  <= 1'b0;
      end else begin
         hs_low     <= hsync_n ? 0 : hs_low + 1;
         since_fall <= hs_fall ? 1 : since_fall + 1;
         vis_run    <= blank ? 0 : vis_run + 1;
         hs_prev    <= hsync_n;
         seen_fall  <= seen_fall || hs_fall;
      end
   end

   AST_BLANK_DARK: assert property (@(posedge pclk) disable iff (!prst_n)
      blank |-> rgb == '0); // R7

   AST_VSYNC_IN_BLANK: assert property (@(posedge pclk) disable iff (!prst_n)
      !vsync_n |-> blank); // R4

   AST_HSYNC_WIDTH: assert property (@(posedge pclk) disable iff (!prst_n)
      $rose(hsync_n) |-> hs_low == H_SYNC); // R3

   AST_LINE_PERIOD: assert property (@(posedge pclk) disable iff (!prst_n)
      (hs_fall && seen_fall) |-> since_fall == H_TOTAL); // R2

   AST_ACTIVE_RUN: assert property (@(posedge pclk) disable iff (!prst_n)
      $rose(blank) |-> vis_run == COLS * 8); // R2

endmodule

bind txtvid_top txtvid_chk #(
   .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .COLS(COLS), .RGB_W(RGB_W)
) u_chk (
   .pclk(pclk), .prst_n(prst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
   .blank(blank), .rgb(rgb)
);

// File: tb/test_txtvid_top.sv
module test_txtvid_top;

   localparam int COLS = 8, ROWS = 4, NG = 128;
   localparam int H_TOTAL = 96, H_FP = 8, H_SYNC = 12;
   localparam int V_TOTAL = 44, V_FP = 3, V_SYNC = 2;
   localparam logic [2:0] FG = 3'b010;
   localparam int ACT_W = COLS * 8, ACT_H = ROWS * 8;
   localparam int BASE = COLS * ROWS, DEPTH = BASE + NG * 8;
   localparam int AW = $clog2(DEPTH);
   localparam int RUN_CYCLES = 3 * H_TOTAL * V_TOTAL + 20;

   typedef struct packed { logic hs; logic vs; logic bl; logic [2:0] rgb; } vid_t;

   logic pclk = 0, hclk = 0, prst_n = 0;
   logic h_we = 0;
   logic [AW-1:0] h_addr = '0;
   logic [7:0] h_wdata = '0, h_rdata;
   logic hsync_n, vsync_n, blank;
   logic [2:0] rgb;

   int checks = 0, failures = 0;
   bit finished = 0;
   logic [7:0] ref_mem [DEPTH];
   vid_t exp_q[$];

   always #2 pclk = ~pclk;
   always #3.5 hclk = ~hclk;

   txtvid_top #(
      .COLS(COLS), .ROWS(ROWS), .NGLYPH(NG), .H_TOTAL(H_TOTAL), .H_FP(H_FP),
      .H_SYNC(H_SYNC), .V_TOTAL(V_TOTAL), .V_FP(V_FP), .V_SYNC(V_SYNC),
      .RGB_W(3), .FG_COLOR(FG), .ADDR_W(AW)
   ) i_txtvid_top (
      .pclk(pclk), .prst_n(prst_n), .hclk(hclk), .h_we(h_we), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .hsync_n(hsync_n), .vsync_n(vsync_n),
      .blank(blank), .rgb(rgb)
   );

   function automatic vid_t predict(int h, int v);
      vid_t e;
      bit vis = (h < ACT_W) && (v < ACT_H);
      int code, gbyte;
      e.hs = !((h >= ACT_W + H_FP) && (h < ACT_W + H_FP + H_SYNC));
      e.vs = !((v >= ACT_H + V_FP) && (v < ACT_H + V_FP + V_SYNC));
      e.bl = !vis;
      e.rgb = 3'b000;
      if (vis) begin
         code  = int'(ref_mem[(v / 8) * COLS + h / 8]) % NG;        // R11
         gbyte = int'(ref_mem[BASE + code * 8 + v % 8]);
         if (((gbyte >> (7 - h % 8)) & 1) == 1) e.rgb = FG;       // R6 MSB first
      end
      return e;
   endfunction

   task automatic check_vid(vid_t exp_v, string tag);
      checks++;
      if (hsync_n !== exp_v.hs) begin
         failures++; $display("FAIL R3 %s hsync_n act=%b exp=%b t=%0t", tag, hsync_n, exp_v.hs, $time);
      end
      if (vsync_n !== exp_v.vs) begin
         failures++; $display("FAIL R4 %s vsync_n act=%b exp=%b t=%0t", tag, vsync_n, exp_v.vs, $time);
      end
      if (blank !== exp_v.bl) begin
         failures++; $display("FAIL R2 %s blank act=%b exp=%b t=%0t", tag, blank, exp_v.bl, $time);
      end
      if (rgb !== exp_v.rgb) begin
         failures++; $display("FAIL R6 R7 R9 R11 %s rgb act=%b exp=%b t=%0t", tag, rgb, exp_v.rgb, $time);
      end
   endtask

   task automatic host_wr(int a, logic [7:0] d);
      @(negedge hclk); h_we = 1; h_addr = AW'(a); h_wdata = d;
      @(negedge hclk); h_we = 0;
      if (a < DEPTH) ref_mem[a] = d;
   endtask

   task automatic host_rd(int a, logic [7:0] exp_v, string req);
      @(negedge hclk); h_we = 0; h_addr = AW'(a);
      @(negedge hclk);
      checks++;
      if (h_rdata !== exp_v) begin
         failures++; $display("FAIL %s read addr=%0d act=%h exp=%h", req, a, h_rdata, exp_v);
      end
   endtask

   // write with the old byte expected on the same edge (R10 read-first)
   task automatic host_rw(int a, logic [7:0] d);
      logic [7:0] old = ref_mem[a];
      @(negedge hclk); h_we = 1; h_addr = AW'(a); h_wdata = d;
      @(negedge hclk); h_we = 0;
      ref_mem[a] = d;
      checks++;
      if (h_rdata !== old) begin
         failures++; $display("FAIL R10 read-during-write addr=%0d act=%h exp=%h", a, h_rdata, old);
      end
   endtask

   task automatic video_loop();
      int h = 0, v = 0;
      vid_t e, rst_v;
      rst_v = '{hs: 1'b1, vs: 1'b1, bl: 1'b1, rgb: 3'b000};
      for (int c = 0; c < RUN_CYCLES; c++) begin
         exp_q.push_back(predict(h, v));
         // R5: outputs follow the counters by four pixel clocks; R1 before that
         if (exp_q.size() > 4) e = exp_q.pop_front();
         else e = rst_v;
         check_vid(e, (c < 4) ? "R1 R5 startup" : "R5 frame");
         h++;
         if (h == H_TOTAL) begin
            h = 0; v++;
            if (v == V_TOTAL) v = 0;
         end
         @(negedge pclk);
      end
   endtask

   task automatic host_seq();
      @(negedge vsync_n);
      // R8 default content
      host_rd(5, 8'd5, "R8");
      host_rd(BASE + 8, 8'h08 ^ 8'hA5, "R8");
      host_rd(DEPTH - 1, 8'hFF ^ 8'hA5, "R8");
      // R11 code with upper bit set, R9 glyph edit for it
      host_rw(0, 8'hC1);
      host_wr(BASE + 8'h41 * 8, 8'hF0);
      host_rd(BASE + 8'h41 * 8, 8'hF0, "R9");
      // R9 another cell and glyph row
      host_wr(COLS + 1, 8'h07);
      host_wr(BASE + 7 * 8 + 3, 8'h81);
      host_rd(COLS + 1, 8'h07, "R9");
      // R10 out-of-range access
      host_wr(DEPTH, 8'h3C);
      host_rd(DEPTH, 8'h00, "R10");
      host_rd(DEPTH - 1, 8'hFF ^ 8'hA5, "R10");
   endtask

   initial begin
      for (int a = 0; a < DEPTH; a++)
         ref_mem[a] = (a < BASE) ? 8'(a % NG) : (8'((a - BASE) % 256) ^ 8'hA5);
      repeat (5) @(negedge pclk);
      // R1 reset state
      checks++;
      if (hsync_n !== 1'b1 || vsync_n !== 1'b1 || blank !== 1'b1 || rgb !== 3'b000) begin
         failures++;
         $display("FAIL R1 reset outputs act=%b%b%b%b exp=1110", hsync_n, vsync_n, blank, rgb);
      end
      prst_n = 1;
      fork
         video_loop();
         host_seq();
      join
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog R2 act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule